// File: doc/BRIEF.md
# Basic-Block Dependency Flag Generator

This unit sits at the rename/dispatch point of an out-of-order core. Instructions reach it in program order, and their architectural register numbers are already decoded. For every instruction it works out three flags. The first says whether the instruction is the first one in the current basic block to write its destination register. The other two say, one for each source operand, whether that operand's value came from before the block started. Downstream history-signature logic uses these flags to pick between a fresh initial history and a history computed inside the block. That choice lets per-register signatures be reset at block boundaries without any single global reset moment.

The unit keeps a bitmask with one bit per architectural register, marking the registers written so far in the current block. A block-start marker instruction clears the mask. Up to four instructions arrive in each cycle, and the lanes are resolved in order: every lane sees the writes of the lanes before it, including a marker earlier in the same group. A pipeline flush loads the mask from a checkpoint supplied with the flush. The flags come out of registers one cycle after the group is presented.

Top module: `bbdf_gen`

## Requirements
- R1: After synchronous reset, all outputs are 0 and no register counts as written in the block, so every source read then reports a block input.
- R2: For a valid non-marker lane, `out_a_prev` (and likewise `out_b_prev`) is 1 exactly when its source register has not been written earlier in the current block.
- R3: For a valid non-marker lane with `in_has_dst` = 1, `out_first_wr` is 1 exactly when the destination register has not yet been written in the current block; from then on that register counts as written.
- R4: Within one group, lane i (bit i of each per-lane vector, register fields at bits [i*5 +: 5]) observes the destination writes of all lanes below i. A lane's own destination write does not affect its own source flags.
- R5: A valid lane with `in_marker` = 1 clears the written mask for itself and for all later lanes and later cycles. Its own three flags are 0 and its `out_valid` is 1.
- R6: A valid lane with `in_has_dst` = 0 leaves the mask unchanged and reports `out_first_wr` = 0.
- R7: A lane with `in_valid` = 0 leaves the mask unchanged and reports `out_valid` = 0 and all three flags 0.
- R8: When `flush` = 1, the group in that cycle is discarded, all outputs are 0 in the next cycle, and the mask becomes `flush_mask` (bit r = 1 means register r counts as written).
- R9: Flags for a group presented at clock edge k appear on the outputs right after edge k and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the group and restore the mask |
| flush_mask | input | 32 | Checkpoint mask; bit r = 1 means register r is written |
| in_valid | input | 4 | Lane holds an instruction |
| in_marker | input | 4 | Lane is a block-start marker |
| in_has_dst | input | 4 | Lane writes a destination register |
| in_dst | input | 20 | Destination register per lane, 5 bits each |
| in_src_a | input | 20 | First source register per lane |
| in_src_b | input | 20 | Second source register per lane |
| out_valid | output | 4 | Registered lane valid |
| out_first_wr | output | 4 | First writer of its destination in this block |
| out_a_prev | output | 4 | First source comes from before the block |
| out_b_prev | output | 4 | Second source comes from before the block |

## Verification
The bench walks all 32 registers through a write-then-rewrite-then-read pattern inside one group. A design that forgot to chain the mask between lanes would call the second writer a first writer and report the read as a block input. Groups with a marker in the middle check that lanes after the marker see an empty mask, while lanes before it are still judged against the old block. A design that applied the clear to the whole group would fail there. Stores, invalid lanes and flushes that carry their own stray writes are each followed by reads of the touched register. Those reads catch a mask that leaked an update or ignored the checkpoint. Long randomized runs against an arithmetic model cover the remaining lane interleavings.

// File: rtl/bbdf_pkg.sv
package bbdf_pkg;
  localparam int DEF_LANES = 4;
  localparam int DEF_REGS  = 32;

  typedef struct packed {
    logic first_wr;
    logic a_prev;
    logic b_prev;
  } lane_flags_t;
endpackage

// File: rtl/bbdf_lane.sv
module bbdf_lane
  import bbdf_pkg::*;
#(
  parameter int NREGS = DEF_REGS,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic              valid,
  input  logic              marker,
  input  logic              has_dst,
  input  logic [RW-1:0]     dst,
  input  logic [RW-1:0]     src_a,
  input  logic [RW-1:0]     src_b,
  input  logic [NREGS-1:0]  mask_in,
  output lane_flags_t       flags,
  output logic [NREGS-1:0]  mask_out
);
  logic [NREGS-1:0] dst_bit;

  always_comb begin
    dst_bit = '0;
    dst_bit[dst] = 1'b1;
  end

  always_comb begin
    flags    = '0;
    mask_out = mask_in;
    if (valid) begin
      if (marker) begin
        mask_out = '0;
      end else begin
        flags.a_prev   = ~mask_in[src_a];
        flags.b_prev   = ~mask_in[src_b];
        flags.first_wr = has_dst & ~mask_in[dst];
        if (has_dst) mask_out = mask_in | dst_bit;
      end
    end
  end
endmodule

// File: rtl/bbdf_mask_state.sv
module bbdf_mask_state #(
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [NREGS-1:0] flush_mask,
  input  logic [NREGS-1:0] next_mask,
  output logic [NREGS-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (flush) mask_q <= flush_mask;
    else            mask_q <= next_mask;
  end
endmodule

// File: rtl/bbdf_out_reg.sv
module bbdf_out_reg #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [LANES-1:0] d_valid,
  input  logic [LANES-1:0] d_first,
  input  logic [LANES-1:0] d_a,
  input  logic [LANES-1:0] d_b,
  output logic [LANES-1:0] q_valid,
  output logic [LANES-1:0] q_first,
  output logic [LANES-1:0] q_a,
  output logic [LANES-1:0] q_b
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      q_valid <= '0;
      q_first <= '0;
      q_a     <= '0;
      q_b     <= '0;
    end else begin
      q_valid <= d_valid;
      q_first <= d_first;
      q_a     <= d_a;
      q_b     <= d_b;
    end
  end
endmodule

// File: rtl/bbdf_gen.sv
module bbdf_gen
  import bbdf_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int NREGS = DEF_REGS,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [NREGS-1:0]    flush_mask,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES-1:0]    in_marker,
  input  logic [LANES-1:0]    in_has_dst,
  input  logic [LANES*RW-1:0] in_dst,
  input  logic [LANES*RW-1:0] in_src_a,
  input  logic [LANES*RW-1:0] in_src_b,
  output logic [LANES-1:0]    out_valid,
  output logic [LANES-1:0]    out_first_wr,
  output logic [LANES-1:0]    out_a_prev,
  output logic [LANES-1:0]    out_b_prev
);
  logic [NREGS-1:0] chain [0:LANES];
  logic [NREGS-1:0] mask_q;
  logic [LANES-1:0] c_first, c_a, c_b;

  bbdf_mask_state #(.NREGS(NREGS)) u_mask (
    .clk(clk), .rst(rst), .flush(flush), .flush_mask(flush_mask),
    .next_mask(chain[LANES]), .mask_q(mask_q)
  );

  assign chain[0] = mask_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_flags_t fl;
    bbdf_lane #(.NREGS(NREGS)) u_lane (
      .valid(in_valid[i]), .marker(in_marker[i]), .has_dst(in_has_dst[i]),
      .dst(in_dst[i*RW +: RW]), .src_a(in_src_a[i*RW +: RW]),
      .src_b(in_src_b[i*RW +: RW]), .mask_in(chain[i]),
      .flags(fl), .mask_out(chain[i+1])
    );
    assign c_first[i] = fl.first_wr;
    assign c_a[i]     = fl.a_prev;
    assign c_b[i]     = fl.b_prev;
  end

  bbdf_out_reg #(.LANES(LANES)) u_out (
    .clk(clk), .rst(rst), .flush(flush),
    .d_valid(in_valid), .d_first(c_first), .d_a(c_a), .d_b(c_b),
    .q_valid(out_valid), .q_first(out_first_wr), .q_a(out_a_prev), .q_b(out_b_prev)
  );
endmodule

// File: rtl/bbdf_gen_chk.sv
module bbdf_gen_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic [LANES-1:0] in_valid,
  input logic [LANES-1:0] in_marker,
  input logic [LANES-1:0] in_has_dst,
  input logic [LANES-1:0] out_valid,
  input logic [LANES-1:0] out_first_wr,
  input logic [LANES-1:0] out_a_prev,
  input logic [LANES-1:0] out_b_prev
);
  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_valid | out_first_wr | out_a_prev | out_b_prev) == '0);

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> out_valid == $past(in_valid));

  // R5
  marker_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && (in_valid & in_marker) != '0) |=>
      ((out_first_wr | out_a_prev | out_b_prev) & $past(in_valid & in_marker)) == '0);

  // R6
  nodst_first_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (out_first_wr & $past(~in_has_dst)) == '0);

  // R7
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_first_wr | out_a_prev | out_b_prev) & ~out_valid) == '0);
endmodule

bind bbdf_gen bbdf_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
  .in_marker(in_marker), .in_has_dst(in_has_dst), .out_valid(out_valid),
  .out_first_wr(out_first_wr), .out_a_prev(out_a_prev), .out_b_prev(out_b_prev)
);

// File: tb/bbdf_gen_tb.sv
module bbdf_gen_tb;
  localparam int L = 4;
  localparam int N = 32;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [N-1:0] flush_mask = '0;
  logic [L-1:0] in_valid = '0, in_marker = '0, in_has_dst = '0;
  logic [L*W-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [L-1:0] out_valid, out_first_wr, out_a_prev, out_b_prev;

  int vectors = 0;
  int fails = 0;
  logic [N-1:0] bm = '0;

  always #5 clk = ~clk;

  bbdf_gen #(.LANES(L), .NREGS(N)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .flush_mask(flush_mask),
    .in_valid(in_valid), .in_marker(in_marker), .in_has_dst(in_has_dst),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_first_wr(out_first_wr),
    .out_a_prev(out_a_prev), .out_b_prev(out_b_prev)
  );

  task automatic setl(input int i, input logic v, input logic m, input logic h,
                      input int d, input int a, input int b);
    in_valid[i] = v; in_marker[i] = m; in_has_dst[i] = h;
    in_dst[i*W +: W] = W'(d); in_src_a[i*W +: W] = W'(a); in_src_b[i*W +: W] = W'(b);
  endtask

  task automatic clr();
    in_valid = '0; in_marker = '0; in_has_dst = '0; flush = 1'b0;
  endtask

  // compute expected from the requirements, clock once, compare, clear inputs
  task automatic step(input string tag);
    logic [L-1:0] ev, ef, ea, eb;
    ev = '0; ef = '0; ea = '0; eb = '0;
    if (flush) begin
      bm = flush_mask;
    end else begin
      for (int i = 0; i < L; i++) begin
        if (in_valid[i]) begin
          ev[i] = 1'b1;
          if (in_marker[i]) bm = '0;
          else begin
            ea[i] = ~bm[in_src_a[i*W +: W]];
            eb[i] = ~bm[in_src_b[i*W +: W]];
            if (in_has_dst[i]) begin
              ef[i] = ~bm[in_dst[i*W +: W]];
              bm[in_dst[i*W +: W]] = 1'b1;
            end
          end
        end
      end
    end
    @(negedge clk);
    vectors++;
    if ({out_valid, out_first_wr, out_a_prev, out_b_prev} != {ev, ef, ea, eb}) begin
      fails++;
      $display("FAIL %s: v/f/a/b got %b %b %b %b expected %b %b %b %b", tag,
               out_valid, out_first_wr, out_a_prev, out_b_prev, ev, ef, ea, eb);
    end
    clr();
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    vectors++;
    if ({out_valid, out_first_wr, out_a_prev, out_b_prev} != '0) begin
      fails++;
      $display("FAIL R1: got %b expected 0", {out_valid, out_first_wr, out_a_prev, out_b_prev});
    end
    rst = 1'b0;
    // R1: every register reads as a block input after reset
    for (int r = 0; r < N; r += 4) begin
      for (int i = 0; i < L; i++) setl(i, 1, 0, 0, 0, r + i, (r + i + 7) % N);
      step("R1");
    end
    // R3 R4 R2: write, rewrite, read per register in one group
    for (int r = 0; r < N; r++) begin
      setl(0, 1, 1, 0, 0, 0, 0);
      setl(1, 1, 0, 1, r, r, r);
      setl(2, 1, 0, 1, r, (r + 1) % N, r);
      setl(3, 1, 0, 0, 0, r, (r + 3) % N);
      step("R3");
    end
    // R5: marker in the middle of a group
    setl(0, 1, 0, 1, 5, 6, 6); setl(1, 1, 1, 0, 0, 0, 0);
    setl(2, 1, 0, 0, 0, 5, 5); setl(3, 1, 0, 1, 5, 5, 5);
    step("R5");
    // R6: store-like lane does not mark its destination field
    setl(0, 1, 1, 0, 0, 0, 0); setl(1, 1, 0, 0, 7, 1, 2);
    setl(2, 1, 0, 0, 0, 7, 7); setl(3, 1, 0, 1, 7, 7, 3);
    step("R6");
    // R7: invalid lane writes nothing
    setl(0, 1, 1, 0, 0, 0, 0); setl(1, 0, 0, 1, 9, 9, 9);
    setl(2, 1, 0, 0, 0, 9, 9); setl(3, 0, 1, 1, 9, 9, 9);
    step("R7");
    // R8: flush with stray writes, then reads of checkpoint and stray registers
    flush_mask = 32'h0000_0008; flush = 1'b1;
    setl(0, 1, 0, 1, 4, 4, 4); setl(1, 1, 1, 0, 0, 0, 0);
    step("R8");
    setl(0, 1, 0, 0, 0, 3, 4); setl(1, 1, 0, 1, 3, 3, 3); setl(2, 1, 0, 1, 4, 4, 4);
    step("R8");
    // R9: back-to-back groups, one-cycle latency each
    setl(0, 1, 0, 1, 10, 10, 11); step("R9");
    setl(0, 1, 0, 1, 10, 10, 11); step("R9");
    // R4: randomized groups over a small register window
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < L; i++)
        setl(i, $urandom_range(0, 7) != 0, $urandom_range(0, 11) == 0,
             $urandom_range(0, 3) != 0, $urandom_range(0, 7),
             $urandom_range(0, 7), $urandom_range(0, 7));
      if ($urandom_range(0, 49) == 0) begin
        flush = 1'b1; flush_mask = N'($urandom);
      end
      step("R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule